// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside the fetch stage of a small 32-bit RISC core and decides, every clock, whether the core must leave its normal instruction stream. Five request lines compete for service: system reset, machine check, an instruction-dependent fault, an external interrupt and a decrementer tick. Requests are levels that the source holds until its handler clears the condition. The block owns the live machine state register (MSR) and two save/restore registers. When it takes an exception, it stores the interrupted program counter in save/restore register 0 and the current MSR in save/restore register 1. It then drops to supervisor mode and issues a one-cycle fetch redirect to the handler vector.

A return-from-interrupt strobe reverses an entry. It copies save/restore register 1 back into the MSR and redirects fetch to the address held in save/restore register 0. Software can also load the MSR directly through a write port. A machine check that arrives while machine-check-enable is clear does not enter a handler. Instead the controller freezes in a checkstop state, and only a system reset request or the hardware reset can release it.

Top module: `exc_entry_ctrl`

## Requirements
- R1: One clock after a non-reset exception is taken, `srr0_q` holds the `cur_pc` and `srr1_q` holds the `msr_q` that were present in the cycle the request was sampled.
- R2: On that entry the MSR is rewritten with external-enable (bit 15), machine-check-enable (bit 12) and the user-mode bit (bit 14, 1 = user) all cleared; every other bit keeps its previous value.
- R3: Every entry raises `redir_valid` for exactly the following cycle, with `redir_addr` equal to VEC_BASE plus 0x100 for system reset, 0x200 for machine check, 0x700 for the fault, 0x500 for external and 0x900 for decrementer.
- R4: When several requests are active together, only the highest one is served, in the order system reset, machine check, fault, external, decrementer.
- R5: While MSR bit 15 is clear, external and decrementer requests cause no redirect and change no register. They stay pending until the bit is set.
- R6: A machine check that wins arbitration while MSR bit 12 is clear sets `checkstop`. In checkstop, `redir_valid` stays low and every request and strobe except system reset is ignored.
- R7: A system reset request wins over everything, including checkstop. It clears both save/restore registers, loads the MSR with 0x0000_1000, clears `checkstop` and redirects to the reset vector.
- R8: A return-from-interrupt strobe with no exception pending loads the MSR from `srr1_q` and redirects to `srr0_q` in the following cycle.
- R9: When an exception and a return-from-interrupt occur in the same cycle, the exception is taken and the strobe is dropped.
- R10: With no exception and no return pending, `msr_wr_en` loads `msr_wr_data` into the MSR by the next cycle.
- R11: After the hardware reset, `redir_valid` and `checkstop` are low, both save/restore registers are zero and the MSR is 0x0000_1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| req_sreset | input | 1 | System reset request |
| req_mcheck | input | 1 | Machine check request |
| req_fault | input | 1 | Instruction-dependent fault request |
| req_ext | input | 1 | External interrupt request |
| req_dec | input | 1 | Decrementer request |
| cur_pc | input | 32 | Address of the instruction about to be interrupted |
| rfi_strobe | input | 1 | Return-from-interrupt executed this cycle |
| msr_wr_en | input | 1 | Software write to the MSR |
| msr_wr_data | input | 32 | Value for the MSR write |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_addr | output | 32 | Redirect target |
| srr0_q | output | 32 | Saved instruction address |
| srr1_q | output | 32 | Saved machine state |
| msr_q | output | 32 | Live machine state register |
| checkstop | output | 1 | Terminal stop state |

## Verification
The hardest situations to reach from the ports need a prepared history. For a return-from-interrupt to show anything, the save/restore registers must already hold known, distinct values. For checkstop to appear, the MSR must first be loaded with machine-check-enable clear. Each stimulus case therefore starts with a hardware reset, loads one MSR pattern and takes a fault at a known PC to fill both save/restore registers, then loads a second MSR that sets the two enable bits. After that it applies one of 256 combinations of the five requests, the two enables and the return strobe. A case that ends in checkstop is held for one more cycle with its requests still asserted, to confirm the state does not release.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NSRC       = 5;
  localparam int SRC_SRESET = 0;
  localparam int SRC_MCHK   = 1;
  localparam int SRC_FAULT  = 2;
  localparam int SRC_EXT    = 3;
  localparam int SRC_DEC    = 4;

  localparam int MSR_EE_BIT = 15;
  localparam int MSR_PR_BIT = 14;
  localparam int MSR_ME_BIT = 12;

  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_SRESET = 3'd1,
    CZ_MCHK   = 3'd2,
    CZ_FAULT  = 3'd3,
    CZ_EXT    = 3'd4,
    CZ_DEC    = 3'd5
  } cause_e;

  // handler offset for each cause
  function automatic logic [11:0] vec_offset(cause_e c);
    case (c)
      CZ_SRESET: return 12'h100;
      CZ_MCHK:   return 12'h200;
      CZ_FAULT:  return 12'h700;
      CZ_EXT:    return 12'h500;
      CZ_DEC:    return 12'h900;
      default:   return 12'h000;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_vec,
  input  logic         ee,
  input  logic         me,
  input  logic         cstop,
  output cause_e       win_cause,
  output logic         win_any,
  output logic         enter_cstop,
  output logic         take
);

  logic [N-1:0] gate;
  logic [N-1:0] elig;

  generate
    for (genvar g = 0; g < N; g++) begin : g_gate
      if (g == SRC_SRESET) begin : g_rst
        assign gate[g] = 1'b1;
      end else if (g >= SRC_EXT) begin : g_async
        assign gate[g] = !cstop && ee;
      end else begin : g_sync
        assign gate[g] = !cstop;
      end
    end
  endgenerate

  assign elig = req_vec & gate;

  // lowest index wins: scan downward so it is assigned last
  always_comb begin
    win_any   = 1'b0;
    win_cause = CZ_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_any   = 1'b1;
        win_cause = cause_e'(3'(i + 1));
      end
    end
  end

  assign enter_cstop = win_any && (win_cause == CZ_MCHK) && !me;
  assign take        = win_any && !enter_cstop;

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] MSR_RESET = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  cause_e          cause,
  input  logic            enter_cstop,
  input  logic            rfi_take,
  input  logic            msrw_take,
  input  logic [XLEN-1:0] msr_wr_data,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] vec_addr,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_addr,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic [XLEN-1:0] msr,
  output logic            cstop
);

  localparam logic [XLEN-1:0] CLR_MASK =
    (XLEN'(1) << MSR_EE_BIT) | (XLEN'(1) << MSR_PR_BIT) | (XLEN'(1) << MSR_ME_BIT);
  localparam logic [XLEN-1:0] MSR_RST = XLEN'(MSR_RESET);

  function automatic logic [XLEN-1:0] entry_msr(logic [XLEN-1:0] m);
    return m & ~CLR_MASK;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      srr0        <= '0;
      srr1        <= '0;
      msr         <= MSR_RST;
      cstop       <= 1'b0;
    end else begin
      redir_valid <= 1'b0;
      if (take && cause == CZ_SRESET) begin
        srr0        <= '0;
        srr1        <= '0;
        msr         <= MSR_RST;
        cstop       <= 1'b0;
        redir_valid <= 1'b1;
        redir_addr  <= vec_addr;
      end else if (enter_cstop) begin
        cstop <= 1'b1;
      end else if (take) begin
        srr0        <= pc;
        srr1        <= msr;
        msr         <= entry_msr(msr);
        redir_valid <= 1'b1;
        redir_addr  <= vec_addr;
      end else if (rfi_take) begin
        msr         <= srr1;
        redir_valid <= 1'b1;
        redir_addr  <= srr0;
      end else if (msrw_take) begin
        msr <= msr_wr_data;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] VEC_BASE  = 32'h0000_0000,
  parameter logic [31:0] MSR_RESET = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_sreset,
  input  logic            req_mcheck,
  input  logic            req_fault,
  input  logic            req_ext,
  input  logic            req_dec,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            rfi_strobe,
  input  logic            msr_wr_en,
  input  logic [XLEN-1:0] msr_wr_data,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_addr,
  output logic [XLEN-1:0] srr0_q,
  output logic [XLEN-1:0] srr1_q,
  output logic [XLEN-1:0] msr_q,
  output logic            checkstop
);

  logic [NSRC-1:0] req_vec;
  cause_e          win_cause;
  logic            win_any;
  logic            enter_cstop;
  logic            take;
  logic            entry_save;
  logic            rfi_take;
  logic            msrw_take;
  logic [XLEN-1:0] vec_addr;

  assign req_vec[SRC_SRESET] = req_sreset;
  assign req_vec[SRC_MCHK]   = req_mcheck;
  assign req_vec[SRC_FAULT]  = req_fault;
  assign req_vec[SRC_EXT]    = req_ext;
  assign req_vec[SRC_DEC]    = req_dec;

  exc_arbiter #(.N(NSRC)) u_arb (
    .req_vec     (req_vec),
    .ee          (msr_q[MSR_EE_BIT]),
    .me          (msr_q[MSR_ME_BIT]),
    .cstop       (checkstop),
    .win_cause   (win_cause),
    .win_any     (win_any),
    .enter_cstop (enter_cstop),
    .take        (take)
  );

  // named events for the checker
  assign entry_save = take && (win_cause != CZ_SRESET);
  assign rfi_take   = rfi_strobe && !win_any && !checkstop;
  assign msrw_take  = msr_wr_en && !rfi_strobe && !win_any && !checkstop;
  assign vec_addr   = XLEN'(VEC_BASE) + XLEN'(vec_offset(win_cause));

  exc_state #(.XLEN(XLEN), .MSR_RESET(MSR_RESET)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .cause       (win_cause),
    .enter_cstop (enter_cstop),
    .rfi_take    (rfi_take),
    .msrw_take   (msrw_take),
    .msr_wr_data (msr_wr_data),
    .pc          (cur_pc),
    .vec_addr    (vec_addr),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .srr0        (srr0_q),
    .srr1        (srr1_q),
    .msr         (msr_q),
    .cstop       (checkstop)
  );

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_sreset,
  input logic            req_mcheck,
  input logic            req_fault,
  input logic            rfi_strobe,
  input logic [XLEN-1:0] cur_pc,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_addr,
  input logic [XLEN-1:0] srr0_q,
  input logic [XLEN-1:0] srr1_q,
  input logic [XLEN-1:0] msr_q,
  input logic            checkstop,
  input logic            entry_save,
  input logic            rfi_take
);

  assert_save_R1: assert property (@(posedge clk) disable iff (!rst_n)
    entry_save |=> (srr0_q == $past(cur_pc)) && (srr1_q == $past(msr_q)));

  assert_super_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_save |=> !msr_q[MSR_EE_BIT] && !msr_q[MSR_ME_BIT] && !msr_q[MSR_PR_BIT]);

  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_q[MSR_EE_BIT] && !req_sreset && !req_mcheck && !req_fault && !rfi_strobe)
      |=> !redir_valid);

  assert_cstop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |-> !redir_valid);

  assert_cstop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (checkstop && !req_sreset) |=> checkstop && $stable(msr_q) && $stable(srr0_q));

  assert_sreset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_sreset |=> redir_valid && !checkstop &&
                   (redir_addr == XLEN'(VEC_BASE) + XLEN'(32'h100)));

  assert_rfi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_take |=> redir_valid && (msr_q == $past(srr1_q)) && (redir_addr == $past(srr0_q)));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

  localparam logic [31:0] MSR_RST = 32'h0000_1000;
  localparam logic [31:0] CLRM    = 32'h0000_D000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_sreset = 0, req_mcheck = 0, req_fault = 0, req_ext = 0, req_dec = 0;
  logic [31:0] cur_pc = '0;
  logic        rfi_strobe = 0, msr_wr_en = 0;
  logic [31:0] msr_wr_data = '0;
  logic        redir_valid, checkstop;
  logic [31:0] redir_addr, srr0_q, srr1_q, msr_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_sreset(req_sreset), .req_mcheck(req_mcheck), .req_fault(req_fault),
    .req_ext(req_ext), .req_dec(req_dec), .cur_pc(cur_pc),
    .rfi_strobe(rfi_strobe), .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .srr0_q(srr0_q), .srr1_q(srr1_q), .msr_q(msr_q), .checkstop(checkstop)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_sreset = 0; req_mcheck = 0; req_fault = 0; req_ext = 0; req_dec = 0;
    rfi_strobe = 0; msr_wr_en = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 256; c++) begin
      logic [4:0]  rq;
      logic        ee, me, rf;
      logic [31:0] m0, p0, mc, p1;
      logic        e_rv, e_cs;
      logic [31:0] e_ra, e_s0, e_s1, e_msr, vec;
      string       tg;
      rq = c[4:0]; ee = c[5]; me = c[6]; rf = c[7];
      m0 = 32'h3C00_0A00 ^ (32'(c) << 16);
      p0 = 32'h0001_0000 + 32'(c) * 8;
      mc = 32'h0000_4055 | (32'(ee) << 15) | (32'(me) << 12);
      p1 = 32'h8000_0000 | (32'(c) << 4);

      idle();
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      if (c == 0) begin
        chk("R11 redir_valid", 32'(redir_valid), 0);
        chk("R11 checkstop", 32'(checkstop), 0);
        chk("R11 srr0", srr0_q, 0);
        chk("R11 srr1", srr1_q, 0);
        chk("R11 msr", msr_q, MSR_RST);
      end
      // load first MSR pattern
      msr_wr_en = 1; msr_wr_data = m0;
      @(negedge clk); msr_wr_en = 0;
      chk("R10 msr write", msr_q, m0);
      // fault at known pc fills save/restore registers
      req_fault = 1; cur_pc = p0;
      @(negedge clk); req_fault = 0;
      chk("R1 srr0 prep", srr0_q, p0);
      chk("R1 srr1 prep", srr1_q, m0);
      chk("R3 fault redirect", redir_valid ? redir_addr : 32'hDEAD, 32'h700);
      chk("R2 msr after entry", msr_q, m0 & ~CLRM);
      // case MSR
      msr_wr_en = 1; msr_wr_data = mc;
      @(negedge clk); msr_wr_en = 0;
      chk("R10 msr write case", msr_q, mc);

      // expected result of the case cycle
      e_rv = 0; e_ra = 32'h0; e_cs = 0; e_s0 = p0; e_s1 = m0; e_msr = mc; vec = 0;
      if (rq[0]) vec = 32'h100;
      else if (rq[1]) vec = me ? 32'h200 : 32'h0;
      else if (rq[2]) vec = 32'h700;
      else if (rq[3] && ee) vec = 32'h500;
      else if (rq[4] && ee) vec = 32'h900;
      if (rq[0]) begin
        e_rv = 1; e_ra = 32'h100; e_s0 = 0; e_s1 = 0; e_msr = MSR_RST;
        tg = "R7";
      end else if (rq[1] && !me) begin
        e_cs = 1; tg = "R6";
      end else if (vec != 0) begin
        e_rv = 1; e_ra = vec; e_s0 = p1; e_s1 = mc; e_msr = mc & ~CLRM;
        tg = rf ? "R9" : ($countones(rq) > 1 ? "R4" : "R3");
      end else if (rf) begin
        e_rv = 1; e_ra = p0; e_msr = m0; tg = "R8";
      end else begin
        tg = "R5";
      end

      {req_dec, req_ext, req_fault, req_mcheck, req_sreset} = rq;
      rfi_strobe = rf; cur_pc = p1;
      @(negedge clk);
      chk($sformatf("%s redir_valid case %0d", tg, c), 32'(redir_valid), 32'(e_rv));
      if (e_rv) chk($sformatf("%s redir_addr case %0d", tg, c), redir_addr, e_ra);
      chk($sformatf("R1 %s srr0 case %0d", tg, c), srr0_q, e_s0);
      chk($sformatf("R1 %s srr1 case %0d", tg, c), srr1_q, e_s1);
      chk($sformatf("R2 %s msr case %0d", tg, c), msr_q, e_msr);
      chk($sformatf("R6 %s checkstop case %0d", tg, c), 32'(checkstop), 32'(e_cs));
      if (e_cs) begin
        // hold requests (no reset) plus a return strobe and MSR write
        rfi_strobe = 1; msr_wr_en = 1; msr_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        chk($sformatf("R6 stays stopped case %0d", c), 32'(checkstop), 1);
        chk($sformatf("R6 no redirect case %0d", c), 32'(redir_valid), 0);
        chk($sformatf("R6 msr frozen case %0d", c), msr_q, mc);
        idle(); req_sreset = 1;
        @(negedge clk); req_sreset = 0;
        chk($sformatf("R7 leaves checkstop case %0d", c), 32'(checkstop), 0);
        chk($sformatf("R7 reset vector case %0d", c), redir_valid ? redir_addr : 32'hDEAD, 32'h100);
      end
      idle();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule